// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Engine

This block is the protocol side of a byte-wide serial EEPROM on a two-wire bus. A fast system clock samples the clock and data lines, picks out start and stop conditions, and runs a state machine. The state machine decodes the device-address byte and the two word-address bytes, then either collects write data or streams read data. The block sends data back only by pulling the data line low, through an output-enable pin. The surrounding logic turns that pin into an open-drain pad.

Write data goes into a page buffer first. Nothing reaches the array until the master ends the transaction with a stop. The stop starts a timed internal write cycle. During that cycle the block does not answer its address, so a master can poll the block to find out when the write is done. When the write-protect input is high at the stop, the stored contents stay as they are. The array is internal, and its size and page size are set by parameters. The default array is smaller than the full 16 KiB so that elaboration stays light; setting ADDR_W to 14 gives the full 16 KiB array.

Top module: `twi_eeprom_slave`

## Requirements
- R1: A falling data line while the synchronised clock is high is a start. A rising data line while it is high is a stop. After reset and after every stop, sda_oe_o is 0, which leaves the line released.
- R2: The device-address byte is acknowledged only when bits 7:4 equal 4'b1010 and bits 3:1 equal sel_i. Bit 0 is the read flag (1 = read). Any other byte gets no acknowledge.
- R3: In a write, the slave pulls the data line low during the 9th clock of each byte: the device address (bit 0 = 0), the upper word-address byte, the lower word-address byte, and every data byte.
- R4: The word address is the low ADDR_W bits of {upper byte, lower byte}. Bits above that width have no effect on the location accessed.
- R5: During a page write only the low PAGE_W address bits advance after each data byte, and the higher bits stay fixed. With a page of 2**PAGE_W bytes, byte 64 and later of a 64-byte page wrap to the start of the page and overwrite bytes sent earlier in the same transaction.
- R6: A stop that follows at least one data byte starts a write cycle lasting WRITE_CYCLES clocks. During that cycle no device address is acknowledged. Once the cycle ends, the device address is acknowledged again.
- R7: If wp_i is 1 when the stop arrives, the array keeps its old contents and no write cycle starts.
- R8: Read data goes out MSB first. The address counter advances by one after the 8th bit of each byte, across the full ADDR_W bits, and wraps from the top address to 0. A read without address bytes continues from the current counter.
- R9: The master writes the two address bytes, sends a repeated start, then sends a device address with bit 0 = 1. The first data byte returned comes from that address.
- R10: When the master acknowledges a read byte, the next byte follows. When it does not, the slave releases the line and waits for a start. A stop returns the slave to idle.
- R11: A start at any point drops the command in progress. Data from a write that ends in a start instead of a stop is never stored.
- R12: sda_oe_o changes only while the synchronised clock is low. A bit the slave drives stays stable for the whole high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired value) |
| sel_i | input | 3 | Strap value matched against device-address bits 3:1 |
| wp_i | input | 1 | Write protect, sampled at the stop that ends a write |
| sda_oe_o | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
The bench goes after page wrap. It writes 66 bytes starting two bytes before the end of a page. A design that carried into the upper address bits would spill into the next page; a design that stopped at 64 bytes would leave the first two bytes stale. It also reads across the top address, where a page-style wrap would return the wrong byte. It polls during the write cycle, where a design that acknowledged while busy would return zero nacks. It runs a protected write, which a design that ignored wp_i would store, and a write cut short by a repeated start, which a design that committed on a start would leave in memory. It also sends address bytes with bits above the address width set, and a device address that fails the code or the select match.

// File: rtl/twi_pkg.sv
package twi_pkg;
    // Protocol phases of the slave
    typedef enum logic [2:0] {
        S_IDLE,
        S_DEV,
        S_ADRH,
        S_ADRL,
        S_WDATA,
        S_ACK,
        S_RDATA,
        S_RACK
    } st_e;

    // Phase entered once an acknowledge bit completes
    typedef enum logic [1:0] {
        N_ADRH,
        N_ADRL,
        N_WDATA,
        N_RDATA
    } nxt_e;

    localparam logic [3:0] DEV_CODE = 4'b1010;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    // [0] first stage, [1] synchronised value, [2] previous synchronised value
    logic [2:0] scl_d, scl_q;
    logic [2:0] sda_d, sda_q;

    always_comb begin
        scl_d = {scl_q[1:0], scl_i};
        sda_d = {sda_q[1:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
        end else begin
            scl_q <= scl_d;
            sda_q <= sda_d;
        end
    end

    assign scl_s     = scl_q[1];
    assign sda_s     = sda_q[1];
    assign scl_rise  =  scl_q[1] & ~scl_q[2];
    assign scl_fall  = ~scl_q[1] &  scl_q[2];
    assign start_det =  scl_q[1] &  scl_q[2] &  sda_q[2] & ~sda_q[1];
    assign stop_det  =  scl_q[1] &  scl_q[2] & ~sda_q[2] &  sda_q[1];
endmodule

// File: rtl/twi_page_buf.sv
module twi_page_buf #(
    parameter int PAGE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr,
    input  logic [PAGE_W-1:0] widx,
    input  logic [7:0]        wdata,
    input  logic [PAGE_W-1:0] ridx,
    output logic [7:0]        rdata,
    output logic              rvalid
);
    localparam int N = 1 << PAGE_W;

    logic [7:0]   data_q [N];
    logic [N-1:0] valid_d, valid_q;

    always_comb begin
        valid_d = valid_q;
        if (clr) begin
            valid_d = '0;
        end else if (wr) begin
            valid_d[widx] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            valid_q <= valid_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr) begin
            data_q[widx] <= wdata;
        end
    end

    assign rdata  = data_q[ridx];
    assign rvalid = valid_q[ridx];
endmodule

// File: rtl/twi_mem_array.sv
module twi_mem_array #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/twi_eeprom_slave.sv
module twi_eeprom_slave
    import twi_pkg::*;
#(
    parameter int ADDR_W       = 11,     // 14 gives the full 16 KiB array
    parameter int PAGE_W       = 6,      // 64-byte page
    parameter int WRITE_CYCLES = 625000  // 5 ms at 125 MHz; must be >= 2**PAGE_W
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] sel_i,
    input  logic       wp_i,
    output logic       sda_oe_o
);
    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int TW_RAW     = $clog2(WRITE_CYCLES + 1);
    localparam int TW         = (TW_RAW > PAGE_W) ? TW_RAW : PAGE_W + 1;
    localparam logic [TW-1:0] T_LAST = TW'(WRITE_CYCLES - 1);
    localparam logic [TW-1:0] T_PAGE = TW'(PAGE_BYTES);

    typedef struct packed {
        st_e               st;
        nxt_e              after;
        logic [3:0]        cnt;
        logic [7:0]        sh;
        logic              oe;
        logic [7:0]        hi;
        logic [ADDR_W-1:0] addr;
        logic              mack;
        logic              wsess;
        logic              busy;
        logic [TW-1:0]     tcnt;
    } ctl_t;

    ctl_t q, d;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic buf_clr, buf_wr, buf_valid, mem_we, busy_w;
    logic [7:0] buf_rdata, mem_rdata;

    twi_line_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    twi_page_buf #(.PAGE_W(PAGE_W)) u_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (buf_clr),
        .wr     (buf_wr),
        .widx   (q.addr[PAGE_W-1:0]),
        .wdata  (q.sh),
        .ridx   (q.tcnt[PAGE_W-1:0]),
        .rdata  (buf_rdata),
        .rvalid (buf_valid)
    );

    // Commit walks the page one byte per clock at the start of the write cycle
    assign mem_we = q.busy && (q.tcnt < T_PAGE) && buf_valid;
    assign busy_w = q.busy;

    twi_mem_array #(.ADDR_W(ADDR_W)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr ({q.addr[ADDR_W-1:PAGE_W], q.tcnt[PAGE_W-1:0]}),
        .wdata (buf_rdata),
        .raddr (q.addr),
        .rdata (mem_rdata)
    );

    always_comb begin
        d       = q;
        buf_clr = 1'b0;
        buf_wr  = 1'b0;

        // Internal write cycle timer
        if (q.busy) begin
            if (q.tcnt == T_LAST) begin
                d.busy = 1'b0;
                d.tcnt = '0;
            end else begin
                d.tcnt = q.tcnt + TW'(1);
            end
        end

        if (stop_det) begin
            d.st    = S_IDLE;
            d.oe    = 1'b0;
            d.wsess = 1'b0;
            if (q.wsess && !wp_i && !q.busy) begin
                d.busy = 1'b1;
                d.tcnt = '0;
            end
        end else if (start_det) begin
            d.st    = S_DEV;
            d.cnt   = '0;
            d.oe    = 1'b0;
            d.wsess = 1'b0;
        end else begin
            case (q.st)
                S_DEV, S_ADRH, S_ADRL, S_WDATA: begin
                    if (scl_rise && (q.cnt < 4'd8)) begin
                        d.sh  = {q.sh[6:0], sda_s};
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall && (q.cnt == 4'd8)) begin
                        d.cnt = '0;
                        case (q.st)
                            S_DEV: begin
                                if ((q.sh[7:4] == DEV_CODE) && (q.sh[3:1] == sel_i) && !q.busy) begin
                                    d.st    = S_ACK;
                                    d.oe    = 1'b1;
                                    d.after = q.sh[0] ? N_RDATA : N_ADRH;
                                end else begin
                                    d.st = S_IDLE;
                                end
                            end
                            S_ADRH: begin
                                d.hi    = q.sh;
                                d.st    = S_ACK;
                                d.oe    = 1'b1;
                                d.after = N_ADRL;
                            end
                            S_ADRL: begin
                                d.addr  = ADDR_W'({q.hi, q.sh});
                                buf_clr = 1'b1;
                                d.st    = S_ACK;
                                d.oe    = 1'b1;
                                d.after = N_WDATA;
                            end
                            default: begin
                                buf_wr  = 1'b1;
                                d.addr[PAGE_W-1:0] = q.addr[PAGE_W-1:0] + PAGE_W'(1);
                                d.wsess = 1'b1;
                                d.st    = S_ACK;
                                d.oe    = 1'b1;
                                d.after = N_WDATA;
                            end
                        endcase
                    end
                end
                S_ACK: begin
                    if (scl_fall) begin
                        d.oe  = 1'b0;
                        d.cnt = '0;
                        case (q.after)
                            N_ADRH:  d.st = S_ADRH;
                            N_ADRL:  d.st = S_ADRL;
                            N_WDATA: d.st = S_WDATA;
                            default: begin
                                d.st = S_RDATA;
                                d.sh = mem_rdata;
                                d.oe = ~mem_rdata[7];
                            end
                        endcase
                    end
                end
                S_RDATA: begin
                    if (scl_rise) begin
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall) begin
                        if (q.cnt == 4'd8) begin
                            d.oe   = 1'b0;
                            d.addr = q.addr + ADDR_W'(1);
                            d.st   = S_RACK;
                        end else begin
                            d.sh = {q.sh[6:0], 1'b0};
                            d.oe = ~q.sh[6];
                        end
                    end
                end
                S_RACK: begin
                    if (scl_rise) begin
                        d.mack = ~sda_s;
                    end else if (scl_fall) begin
                        if (q.mack) begin
                            d.st  = S_RDATA;
                            d.cnt = '0;
                            d.sh  = mem_rdata;
                            d.oe  = ~mem_rdata[7];
                        end else begin
                            d.st = S_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o = q.oe;
endmodule

// File: rtl/twi_eeprom_checker.sv
module twi_eeprom_checker (
    input logic clk,
    input logic rst_n,
    input logic scl_s,
    input logic sda_oe,
    input logic start_det,
    input logic stop_det,
    input logic busy,
    input logic wp
);
    // R12: the drive changes only in the low phase of the synchronised clock
    p_drive_low_phase_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) && !$past(start_det) && !$past(stop_det) |-> !scl_s);

    // R6: nothing is acknowledged while the write cycle runs
    p_busy_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_oe);

    // R7: a protected stop does not launch a write cycle
    p_protect_no_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det && wp && !busy |=> !busy);

    // R10: a stop leaves the line released
    p_stop_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    // R11: a start drops any drive in progress
    p_start_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_oe);
endmodule

bind twi_eeprom_slave twi_eeprom_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .sda_oe    (sda_oe_o),
    .start_det (start_det),
    .stop_det  (stop_det),
    .busy      (busy_w),
    .wp        (wp_i)
);

// File: tb/sim_twi_eeprom_slave.sv
module sim_twi_eeprom_slave;
    localparam int AW  = 11;
    localparam int PW  = 6;
    localparam int WC  = 300;
    localparam int Q   = 4;
    localparam int MEM = 1 << AW;
    localparam int PG  = 1 << PW;
    localparam logic [2:0] SEL = 3'b101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic wp = 1'b0;
    logic sda_oe;
    wire  sda_bus = m_sda & ~sda_oe;

    always #4 clk = ~clk;

    twi_eeprom_slave #(.ADDR_W(AW), .PAGE_W(PW), .WRITE_CYCLES(WC)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (m_scl),
        .sda_i    (sda_bus),
        .sel_i    (SEL),
        .wp_i     (wp),
        .sda_oe_o (sda_oe)
    );

    int checks = 0;
    int fails = 0;
    int glitches = 0;
    bit done = 1'b0;
    logic [7:0] shadow [MEM];
    logic [7:0] wbuf [$];
    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic [7:0] got;
    logic [AW-1:0] ptr = '0;
    event rd_ev;

    task automatic check_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: pops one expected byte per byte the master receives
    initial begin : monitor
        logic [7:0] e;
        string t;
        forever begin
            @(rd_ev);
            if (exp_q.size() == 0) begin
                check_eq("R8 scoreboard underflow", 1, 0);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check_eq(t, int'(got), int'(e));
            end
        end
    end

    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic start_c();
        m_sda = 1'b1; qwait();
        m_scl = 1'b1; qwait();
        m_sda = 1'b0; qwait();
        m_scl = 1'b0; qwait();
    endtask

    task automatic stop_c();
        m_sda = 1'b0; qwait();
        m_scl = 1'b1; qwait();
        m_sda = 1'b1; qwait();
    endtask

    task automatic bit_out(input logic b);
        m_sda = b; qwait();
        m_scl = 1'b1; qwait(); qwait();
        m_scl = 1'b0; qwait();
    endtask

    task automatic bit_in(output logic b);
        m_sda = 1'b1; qwait();
        m_scl = 1'b1; qwait();
        b = sda_bus;
        qwait();
        if (sda_bus !== b) glitches++;
        m_scl = 1'b0; qwait();
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) bit_out(v[i]);
        bit_in(a);
        ack = ~a;
    endtask

    task automatic recv_byte(output logic [7:0] v, input logic mack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            bit_in(b);
            v[i] = b;
        end
        bit_out(mack ? 1'b0 : 1'b1);
    endtask

    function automatic logic [7:0] dev(input logic rd);
        return {4'b1010, SEL, rd};
    endfunction

    task automatic do_write(input logic [15:0] a, input bit stop_it, input string tag);
        logic ack;
        int base;
        start_c();
        send_byte(dev(1'b0), ack); check_eq({"R3 device ack ", tag}, int'(ack), 1);
        send_byte(a[15:8], ack);   check_eq({"R3 upper addr ack ", tag}, int'(ack), 1);
        send_byte(a[7:0], ack);    check_eq({"R3 lower addr ack ", tag}, int'(ack), 1);
        foreach (wbuf[i]) begin
            send_byte(wbuf[i], ack);
            check_eq({"R3 data ack ", tag}, int'(ack), 1);
        end
        if (stop_it) begin
            stop_c();
            base = int'(a[AW-1:0]);
            if (!wp && wbuf.size() > 0) begin
                foreach (wbuf[i]) shadow[(base & ~(PG - 1)) | ((base + i) & (PG - 1))] = wbuf[i];
            end
        end
    endtask

    task automatic poll(output int n);
        logic ack;
        n = 0;
        forever begin
            start_c();
            send_byte(dev(1'b0), ack);
            stop_c();
            if (ack || n > 50) break;
            n++;
        end
    endtask

    task automatic do_read(input logic [15:0] a, input int n, input bit random, input string tag);
        logic ack;
        logic [7:0] v;
        if (random) begin
            start_c();
            send_byte(dev(1'b0), ack); check_eq("R9 dummy write ack", int'(ack), 1);
            send_byte(a[15:8], ack);
            send_byte(a[7:0], ack);
            ptr = a[AW-1:0];
        end
        start_c();
        send_byte(dev(1'b1), ack); check_eq({"R9 read device ack ", tag}, int'(ack), 1);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(shadow[ptr]);
            tag_q.push_back(tag);
            recv_byte(v, i < n - 1);
            got = v;
            -> rd_ev;
            ptr = ptr + 1'b1;
        end
        stop_c();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : driver
        logic ack;
        int n;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check_eq("R1 line released after reset", int'(sda_oe), 0);

        // R2: mismatched select and mismatched code
        start_c(); send_byte({4'b1010, 3'b011, 1'b0}, ack); stop_c();
        check_eq("R2 wrong select not acknowledged", int'(ack), 0);
        start_c(); send_byte({4'b1011, SEL, 1'b0}, ack); stop_c();
        check_eq("R2 wrong code not acknowledged", int'(ack), 0);

        // R3, R6: single byte and acknowledge polling
        wbuf = '{8'h5A};
        do_write(16'h0123, 1'b1, "byte");
        poll(n);
        check_eq("R6 polls refused during write cycle", int'(n > 0), 1);
        check_eq("R6 write cycle ends", int'(n <= 50), 1);
        do_read(16'h0123, 1, 1'b1, "R9 random read");

        // R8, R10: sequential then current-address read
        wbuf = '{8'hA0, 8'hA1, 8'hA2, 8'hA3, 8'hA4};
        do_write(16'h0200, 1'b1, "short page");
        poll(n);
        do_read(16'h0200, 4, 1'b1, "R10 sequential read");
        do_read(16'h0000, 1, 1'b0, "R8 current address read");

        // R5: 66 bytes from offset 62 wrap inside the page
        wbuf.delete();
        for (int i = 0; i < 66; i++) wbuf.push_back(8'(8'h10 + i));
        do_write(16'h033E, 1'b1, "wrap");
        poll(n);
        do_read(16'h0300, 64, 1'b1, "R5 page wrap contents");

        // R7: write protect
        wp = 1'b1;
        wbuf = '{8'hEE};
        do_write(16'h0123, 1'b1, "protected");
        poll(n);
        check_eq("R7 no write cycle under protect", n, 0);
        wp = 1'b0;
        do_read(16'h0123, 1, 1'b1, "R7 protected byte unchanged");

        // R11: write cut short by a repeated start
        wbuf = '{8'h77};
        do_write(16'h0123, 1'b0, "aborted");
        do_read(16'h0123, 1, 1'b1, "R11 aborted write not stored");

        // R4: bits above the address width ignored
        wbuf = '{8'h3C};
        do_write(16'hF805, 1'b1, "high bits");
        poll(n);
        do_read(16'h0005, 1, 1'b1, "R4 upper address bits ignored");

        // R8: read wraps from the top address to zero
        wbuf = '{8'h91};
        do_write(16'h07FF, 1'b1, "top");
        poll(n);
        wbuf = '{8'h92};
        do_write(16'h0000, 1'b1, "bottom");
        poll(n);
        do_read(16'h07FF, 2, 1'b1, "R8 address rollover");

        check_eq("R10 line released after stop", int'(sda_oe), 0);
        check_eq("R12 slave bits stable in high phase", glitches, 0);
        repeat (4) @(negedge clk);
        check_eq("R8 scoreboard drained", exp_q.size(), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule